// File: doc/BRIEF.md
# Serial CORDIC Quadrature Oscillator

This block is a numerically controlled oscillator that produces a sine and cosine sample pair from a 32-bit phase accumulator. The samples come from an iterative CORDIC rotator that performs one micro-rotation per enabled clock. A conversion therefore takes N enabled cycles, where N is the magnitude precision of the signed outputs. At the first enabled cycle of each conversion the block captures a phase step and two modulation words. A phase offset is added to the angle of the current sample. A frequency offset is added to the step before the accumulator advances. The output frequency is step × f_clk / (N × 2^32).

The top two bits of the angle select the quadrant. Angles in the second and third quadrants are moved by half a turn into the range ±π/2, and both results are negated afterwards. The rotating vector starts at the reciprocal of the CORDIC gain, so the outputs reach full scale without a final multiply. A one-cycle strobe marks each finished pair. Between strobes the output values carry no meaning.

Top module: `nco_serial_cordic`

## Requirements
- R1: A low level on reset_n at a clock edge clears the accumulator, the conversion progress, out_valid, fsin and fcos to zero. After release, the first strobe comes at the edge of the N-th enabled cycle.
- R2: While clken is low, nothing advances and no strobe is issued. Disabled cycles only stretch the current conversion.
- R3: out_valid is high for exactly one clock, once per N enabled cycles, after the edge of the last enabled cycle of a conversion.
- R4: phase_step, phase_mod and freq_mod are used only at the first enabled cycle of a conversion. Their values at any other cycle have no effect on any sample.
- R5: The angle of a sample is the accumulator plus phase_mod, modulo 2^32. The accumulator then advances by phase_step + freq_mod, modulo 2^32. The first sample after reset uses an accumulator value of 0.
- R6: With A = 2^(N−1)−1 and θ the angle in units of 2^−32 turn, fsin is within 3 LSB of A·sin(2πθ/2^32) and fcos is within 3 LSB of A·cos(2πθ/2^32), in all four quadrants.
- R7: A strobed output never lies outside ±A, so the most negative code never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset_n | input | 1 | Synchronous reset, active low |
| clken | input | 1 | Clock enable; progress only when high |
| phase_step | input | 32 | Phase increment per conversion |
| phase_mod | input | 32 | Phase offset added to the current sample's angle |
| freq_mod | input | 32 | Offset added to the increment |
| fsin | output | N | Signed sine sample |
| fcos | output | N | Signed cosine sample |
| out_valid | output | 1 | One-clock strobe marking a finished pair |

## Verification
The hardest case to reach from the ports is a control word that changes in the middle of a conversion, because it must leave the result untouched. The stimulus redraws all three control words on every cycle while clken toggles at random. The reference model uses only the values present at the first enabled cycle of each conversion, so a design that samples at any other cycle shows a wrong angle. Exact quarter-turn offsets with a zero step drive the outputs to full scale and into every quadrant. A reset in the middle of a conversion checks that the next conversion restarts cleanly.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int PHASE_W = 32;
    localparam int ATAN_DEPTH = 24;
    localparam real CORDIC_INV_GAIN = 0.6072529350088813;

    typedef logic [PHASE_W-1:0] phase_t;

    // control words captured at the start of a conversion
    typedef struct packed {
        phase_t step;
        phase_t pmod;
        phase_t fmod;
    } nco_ctrl_t;

    // post-rotation correction for the folded half-turn
    typedef enum logic {
        FOLD_KEEP   = 1'b0,
        FOLD_NEGATE = 1'b1
    } fold_e;

    // atan(2^-idx) in units of 2^-32 turn
    function automatic phase_t atan_angle(input int unsigned idx);
        case (idx)
            0:       return 32'd536870912;
            1:       return 32'd316933406;
            2:       return 32'd167458907;
            3:       return 32'd85004756;
            4:       return 32'd42667331;
            5:       return 32'd21354465;
            6:       return 32'd10679838;
            7:       return 32'd5340245;
            8:       return 32'd2670163;
            9:       return 32'd1335087;
            10:      return 32'd667544;
            11:      return 32'd333772;
            12:      return 32'd166886;
            13:      return 32'd83443;
            14:      return 32'd41722;
            15:      return 32'd20861;
            16:      return 32'd10430;
            17:      return 32'd5215;
            18:      return 32'd2608;
            19:      return 32'd1304;
            20:      return 32'd652;
            21:      return 32'd326;
            22:      return 32'd163;
            23:      return 32'd81;
            default: return '0;
        endcase
    endfunction

    // start magnitude: gain reciprocal times full scale, with guard bits
    function automatic int init_magnitude(input int n, input int g);
        real a;
        a = CORDIC_INV_GAIN * (2.0 ** (n - 1) - 1.0) * (2.0 ** g);
        return $rtoi(a + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_unit.sv
module nco_phase_unit
    import nco_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  nco_ctrl_t                 ctrl,
    output logic signed [PHASE_W-1:0] residual,
    output fold_e                     fold_q
);

    phase_t acc_q;
    phase_t theta;
    logic   flip_now;

    assign theta    = acc_q + ctrl.pmod;
    // second and third quadrants: move by half a turn
    assign flip_now = theta[PHASE_W-1] ^ theta[PHASE_W-2];
    assign residual = $signed(theta ^ {flip_now, {(PHASE_W-1){1'b0}}});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            fold_q <= FOLD_KEEP;
        end else if (start) begin
            acc_q  <= acc_q + ctrl.step + ctrl.fmod;
            fold_q <= flip_now ? FOLD_NEGATE : FOLD_KEEP;
        end
    end

endmodule

// File: rtl/nco_cordic_iter.sv
module nco_cordic_iter
    import nco_pkg::*;
#(
    parameter int N      = 12,
    parameter int IW     = 17,
    parameter int X_INIT = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic signed [PHASE_W-1:0] z_init,
    output logic                      start,
    output logic                      last,
    output logic signed [IW-1:0]      x_nxt,
    output logic signed [IW-1:0]      y_nxt
);

    localparam int CW = $clog2(N);
    localparam logic [CW-1:0] LAST_ITER = CW'(N - 1);
    localparam logic signed [IW-1:0] X0 = IW'(X_INIT);

    logic [CW-1:0]               iter_q;
    logic signed [IW-1:0]        x_q, y_q, x_in, y_in;
    logic signed [PHASE_W-1:0]   z_q, z_in, z_nxt, step_ang;
    logic                        dir_pos;

    assign start = en && (iter_q == '0);
    assign last  = en && (iter_q == LAST_ITER);

    // first micro-rotation works on the preloaded vector directly
    always_comb begin
        x_in     = (iter_q == '0) ? X0 : x_q;
        y_in     = (iter_q == '0) ? '0 : y_q;
        z_in     = (iter_q == '0) ? z_init : z_q;
        step_ang = $signed(atan_angle(32'(iter_q)));
        dir_pos  = !z_in[PHASE_W-1];
        if (dir_pos) begin
            x_nxt = x_in - (y_in >>> iter_q);
            y_nxt = y_in + (x_in >>> iter_q);
            z_nxt = z_in - step_ang;
        end else begin
            x_nxt = x_in + (y_in >>> iter_q);
            y_nxt = y_in - (x_in >>> iter_q);
            z_nxt = z_in + step_ang;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iter_q <= '0;
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
        end else if (en) begin
            iter_q <= last ? '0 : iter_q + 1'b1;
            x_q    <= x_nxt;
            y_q    <= y_nxt;
            z_q    <= z_nxt;
        end
    end

endmodule

// File: rtl/nco_out_stage.sv
module nco_out_stage
    import nco_pkg::*;
#(
    parameter int N  = 12,
    parameter int G  = 4,
    parameter int IW = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 last,
    input  fold_e                fold,
    input  logic signed [IW-1:0] x_fin,
    input  logic signed [IW-1:0] y_fin,
    output logic signed [N-1:0]  fsin,
    output logic signed [N-1:0]  fcos,
    output logic                 valid
);

    localparam logic signed [IW:0] AMAX = (IW+1)'((2 ** (N - 1)) - 1);
    localparam logic signed [IW:0] HALF = (IW+1)'(2 ** (G - 1));

    // drop guard bits with rounding, clamp to the symmetric range
    function automatic logic signed [N-1:0] shrink(input logic signed [IW-1:0] v);
        logic signed [IW:0] r;
        r = ($signed({v[IW-1], v}) + HALF) >>> G;
        if (r > AMAX)       return AMAX[N-1:0];
        else if (r < -AMAX) return -AMAX[N-1:0];
        else                return r[N-1:0];
    endfunction

    logic signed [N-1:0] s_m, c_m;

    assign s_m = shrink(y_fin);
    assign c_m = shrink(x_fin);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsin  <= '0;
            fcos  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= last;
            if (last) begin
                fsin <= (fold == FOLD_NEGATE) ? -s_m : s_m;
                fcos <= (fold == FOLD_NEGATE) ? -c_m : c_m;
            end
        end
    end

endmodule

// File: rtl/nco_serial_cordic.sv
module nco_serial_cordic
    import nco_pkg::*;
#(
    parameter int N = 12,
    parameter int G = 4
) (
    input  logic               clk,
    input  logic               reset_n,
    input  logic               clken,
    input  logic [31:0]        phase_step,
    input  logic [31:0]        phase_mod,
    input  logic [31:0]        freq_mod,
    output logic signed [N-1:0] fsin,
    output logic signed [N-1:0] fcos,
    output logic               out_valid
);

    localparam int IW     = N + G + 1;
    localparam int X_INIT = init_magnitude(N, G);

    nco_ctrl_t                 ctrl;
    logic                      start, last;
    logic signed [PHASE_W-1:0] residual;
    fold_e                     fold_q;
    logic signed [IW-1:0]      x_fin, y_fin;

    assign ctrl = '{step: phase_step, pmod: phase_mod, fmod: freq_mod};

    nco_phase_unit u_phase (
        .clk      (clk),
        .rst_n    (reset_n),
        .start    (start),
        .ctrl     (ctrl),
        .residual (residual),
        .fold_q   (fold_q)
    );

    nco_cordic_iter #(.N(N), .IW(IW), .X_INIT(X_INIT)) u_iter (
        .clk    (clk),
        .rst_n  (reset_n),
        .en     (clken),
        .z_init (residual),
        .start  (start),
        .last   (last),
        .x_nxt  (x_fin),
        .y_nxt  (y_fin)
    );

    nco_out_stage #(.N(N), .G(G), .IW(IW)) u_out (
        .clk   (clk),
        .rst_n (reset_n),
        .last  (last),
        .fold  (fold_q),
        .x_fin (x_fin),
        .y_fin (y_fin),
        .fsin  (fsin),
        .fcos  (fcos),
        .valid (out_valid)
    );

endmodule

// File: rtl/nco_serial_cordic_chk.sv
module nco_serial_cordic_chk #(
    parameter int N = 12
) (
    input logic               clk,
    input logic               reset_n,
    input logic               clken,
    input logic signed [N-1:0] fsin,
    input logic signed [N-1:0] fcos,
    input logic               out_valid
);

    localparam int A  = (2 ** (N - 1)) - 1;
    localparam int RL = (A - 6) * (A - 6);
    localparam int RH = (A + 6) * (A + 6);

    // enabled edges since the edge that produced the last strobe
    int gap;
    always_ff @(posedge clk) begin
        if (!reset_n)       gap <= 0;
        else if (out_valid) gap <= clken ? 1 : 0;
        else if (clken && gap <= N) gap <= gap + 1;
    end

    int r2;
    assign r2 = int'(fsin) * int'(fsin) + int'(fcos) * int'(fcos);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !reset_n |=> (!out_valid && fsin == '0 && fcos == '0));

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!reset_n)
        out_valid |=> !out_valid);

    // R2
    valid_needs_en_chk: assert property (@(posedge clk) disable iff (!reset_n)
        out_valid |-> $past(clken));

    // R3
    valid_spacing_chk: assert property (@(posedge clk) disable iff (!reset_n)
        out_valid |-> gap == N);

    // R7
    output_range_chk: assert property (@(posedge clk) disable iff (!reset_n)
        out_valid |-> (int'(fsin) >= -A && int'(fsin) <= A && int'(fcos) >= -A && int'(fcos) <= A));

    // R6
    radius_chk: assert property (@(posedge clk) disable iff (!reset_n)
        out_valid |-> (r2 >= RL && r2 <= RH));

endmodule

bind nco_serial_cordic nco_serial_cordic_chk #(.N(N)) u_chk (
    .clk       (clk),
    .reset_n   (reset_n),
    .clken     (clken),
    .fsin      (fsin),
    .fcos      (fcos),
    .out_valid (out_valid)
);

// File: tb/nco_serial_cordic_bench.sv
module nco_serial_cordic_bench;

    localparam int  N   = 12;
    localparam int  A   = (2 ** (N - 1)) - 1;
    localparam real TOL = 3.0;
    localparam real PI  = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               reset_n = 1'b0;
    logic               clken = 1'b0;
    logic [31:0]        phase_step = '0;
    logic [31:0]        phase_mod = '0;
    logic [31:0]        freq_mod = '0;
    logic signed [N-1:0] fsin, fcos;
    logic               out_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // reference model state
    int          m_cnt = 0;
    logic [31:0] m_acc = '0;
    logic [31:0] m_theta = '0;

    always #2 clk = ~clk;

    nco_serial_cordic #(.N(N)) u_nco_serial_cordic (
        .clk        (clk),
        .reset_n    (reset_n),
        .clken      (clken),
        .phase_step (phase_step),
        .phase_mod  (phase_mod),
        .freq_mod   (freq_mod),
        .fsin       (fsin),
        .fcos       (fcos),
        .out_valid  (out_valid)
    );

    task automatic expect_bit(input string req, input logic got, input logic want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: out_valid=%0b expected %0b at cycle %0d", req, got, want, cyc);
        end
    endtask

    task automatic expect_near(input string req, input string what, input int got, input real want);
        real d;
        checks++;
        d = real'(got) - want;
        if (d > TOL || d < -TOL) begin
            errors++;
            $display("FAIL %s: %s=%0d expected %f at cycle %0d", req, what, got, want, cyc);
        end
    endtask

    task automatic expect_range(input string req, input int got);
        checks++;
        if (got > A || got < -A) begin
            errors++;
            $display("FAIL %s: value %0d expected within +/-%0d at cycle %0d", req, got, A, cyc);
        end
    endtask

    task automatic run_cycle(input logic rn, input logic en, input logic [31:0] st,
                             input logic [31:0] pm, input logic [31:0] fm, input string tag);
        logic want_v;
        real  th;
        reset_n    = rn;
        clken      = en;
        phase_step = st;
        phase_mod  = pm;
        freq_mod   = fm;
        @(posedge clk);
        #1;
        cyc++;
        if (!rn) begin
            m_cnt = 0;
            m_acc = '0;
            expect_bit("R1", out_valid, 1'b0);
            expect_near("R1", "fsin", int'(fsin), 0.0);
            expect_near("R1", "fcos", int'(fcos), 0.0);
        end else begin
            want_v = 1'b0;
            if (en) begin
                if (m_cnt == 0) begin
                    m_theta = m_acc + pm;
                    m_acc   = m_acc + st + fm;
                end
                if (m_cnt == N - 1) want_v = 1'b1;
                m_cnt = (m_cnt + 1) % N;
            end
            expect_bit(tag, out_valid, want_v);
            if (want_v && out_valid) begin
                th = 2.0 * PI * real'(m_theta) / 4294967296.0;
                expect_near({"R6/", tag}, "fsin", int'(fsin), real'(A) * $sin(th));
                expect_near({"R6/", tag}, "fcos", int'(fcos), real'(A) * $cos(th));
                expect_range("R7", int'(fsin));
                expect_range("R7", int'(fcos));
            end
        end
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) run_cycle(1'b0, 1'b1, 32'h0100_0000, '0, '0, "R1");

        // R2: clken low, nothing advances
        for (int i = 0; i < 3 * N; i++) run_cycle(1'b1, 1'b0, 32'h0100_0000, '0, '0, "R2");

        // R3 / R5: steady tone, first strobe after N enabled cycles
        for (int i = 0; i < 40 * N; i++) run_cycle(1'b1, 1'b1, 32'h0100_0000, '0, '0, "R3");

        // R6: quarter turns and an eighth turn with zero step
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 2 * N; i++)
                run_cycle(1'b1, 1'b1, '0, 32'(k) << 29, '0, "R6");
        end

        // R4: control words redrawn every cycle
        for (int i = 0; i < 60 * N; i++)
            run_cycle(1'b1, 1'b1, $urandom, $urandom, $urandom, "R4");

        // R2: random clock enable with changing controls
        for (int i = 0; i < 70 * N; i++)
            run_cycle(1'b1, ($urandom % 10) < 6, $urandom, $urandom, $urandom, "R2");

        // R1: reset in the middle of a conversion
        for (int i = 0; i < 5; i++) run_cycle(1'b1, 1'b1, 32'h0300_0000, '0, '0, "R1");
        run_cycle(1'b0, 1'b1, 32'h0300_0000, '0, '0, "R1");
        for (int i = 0; i < 4 * N; i++) run_cycle(1'b1, 1'b1, 32'h0300_0000, '0, '0, "R1");

        // R5: negative frequency through wrap, plus offset
        for (int i = 0; i < 40 * N; i++)
            run_cycle(1'b1, 1'b1, 32'hF700_0000, 32'h4000_0000, 32'h0010_0000, "R5");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule